// File: doc/BRIEF.md
# Delayed-Branch Next-Fetch Address Unit

This block works out where instruction fetch goes next on a processor whose control transfers have a single delay slot and an annul flag. Every cycle it takes the address of the instruction being executed, the address already queued after it, a sign-extended displacement, the annul flag, a branch kind, a 4-bit condition field and the condition state. From these it produces the next two fetch addresses. Those two addresses become the block's outputs one clock later, together with a taken flag and an illegal-encoding flag.

There are three condition sources. The first is a set of integer flags held as two 4-bit groups, one for 32-bit results and one for 64-bit results. The second is four 2-bit floating-point compare results. The third is a signed test of a register operand against zero. On the flag-based kinds, condition value 8 always branches and condition value 0 never branches. The annul flag has a different effect on each case. An unconditional branch with annul set jumps straight to the target and drops the delay slot. A never-branch with annul set skips the delay slot and continues in line. A conditional branch drops its delay slot only when it falls through.

Top module: `dslot_npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs are zero in the following cycle. After reset, each output shows the inputs sampled at the previous clock edge, so the latency is exactly one cycle.
- R2: Unconditional branch (`kind_i` 0 or 1, `cond_i` = 8) with annul set gives `npc_o` = pc+disp, `nnpc_o` = pc+disp+4 and `taken_o` = 1.
- R3: Unconditional branch with annul clear gives `npc_o` = npc, `nnpc_o` = pc+disp and `taken_o` = 1.
- R4: Never-branch (`kind_i` 0 or 1, `cond_i` = 0) gives `taken_o` = 0. With annul clear the addresses are npc and npc+4. With annul set they are npc+4 and npc+8.
- R5: A conditional branch whose condition holds gives `npc_o` = npc, `nnpc_o` = pc+disp and `taken_o` = 1, whatever the annul flag.
- R6: A conditional branch whose condition fails gives `taken_o` = 0. With annul clear the addresses are npc and npc+4. With annul set they are npc+4 and npc+8.
- R7: `kind_i` selects the branch kind: 0 = integer flags, 1 = floating-point compare, 2 = register against zero, 3 = no branch. Kind 3 always gives npc and npc+4 with `taken_o` = 0.
- R8: Integer flags: `sel_i` 0 selects `ccr_i[3:0]` and `sel_i` 2 selects `ccr_i[7:4]`. Within a group, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. For `cond_i[2:0]` values 1 to 7 the tests are Z, Z|(N^V), N^V, C|Z, C, N and V; 0 is false. `cond_i[3]` = 1 inverts the result.
- R9: Floating point: field k sits at `fcc_i[2k+1:2k]` and `sel_i` = k picks it, for all four values of k. A field value of 0 means equal, 1 less, 2 greater and 3 unordered. Taking U as unordered, G as greater, L as less and E as equal, `cond_i` values 1 to 7 test U|L|G, L|G, U|L, L, U|G, G and U. Values 9 to 15 are the complements of 1 to 7 in the same order.
- R10: Register kind: `cond_i[2:0]` values 1, 2, 3, 5, 6 and 7 test the signed 64-bit `reg_val_i` for ==0, <=0, <0, !=0, >0 and >=0. `cond_i[3]` is ignored.
- R11: The following encodings are illegal: register kind with `cond_i[1:0]` = 0, and integer kind with `sel_i` 1 or 3. An illegal encoding gives `illegal_o` = 1, `taken_o` = 0 and addresses npc and npc+4, whatever the annul flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kind_i | input | 2 | Branch kind (see R7) |
| cond_i | input | 4 | Condition field |
| sel_i | input | 2 | Flag-group or compare-field selector |
| annul_i | input | 1 | Annul flag of the branch |
| pc_i | input | ADDR_W | Address of the executing instruction |
| npc_i | input | ADDR_W | Address queued after it (delay slot) |
| disp_i | input | ADDR_W | Sign-extended byte displacement |
| ccr_i | input | 8 | Integer flags, two 4-bit groups |
| fcc_i | input | 2*NFCC | Floating-point compare fields |
| reg_val_i | input | REG_W | Register operand, signed |
| npc_o | output | ADDR_W | Next queued fetch address |
| nnpc_o | output | ADDR_W | Fetch address after that |
| taken_o | output | 1 | Branch taken |
| illegal_o | output | 1 | Reserved encoding seen |

## Verification
The bench sweeps every condition code against every integer flag pattern and every selector. It also sweeps every floating-point condition against every compare value in each of the four fields, and every register code against values at and around zero and at the signed extremes. Each sweep runs with annul both clear and set. The corner cases are these. If a design confused the always and never encodings, the taken flag would be inverted. If it applied taken-branch annul behaviour to the unconditional branch, the delay slot would execute where it must be skipped. If it annulled a taken conditional branch, it would lose a delay slot that must run. If it treated the register value as unsigned, negative values would compare as large positives. If it let an illegal encoding branch, it would send fetch to a target it must not reach.

// File: rtl/dnpc_pkg.sv
package dnpc_pkg;
  localparam logic [1:0] KIND_ICC  = 2'd0;
  localparam logic [1:0] KIND_FCC  = 2'd1;
  localparam logic [1:0] KIND_REG  = 2'd2;
  localparam logic [1:0] KIND_NONE = 2'd3;

  localparam logic [3:0] COND_NEVER  = 4'd0;
  localparam logic [3:0] COND_ALWAYS = 4'd8;

  typedef enum logic [1:0] {
    NX_SEQ    = 2'd0,
    NX_ALWAYS = 2'd1,
    NX_NEVER  = 2'd2,
    NX_COND   = 2'd3
  } nx_mode_e;
endpackage

// File: rtl/icc_eval.sv
module icc_eval #(
  parameter int NIB  = 4,
  parameter int NSET = 2
) (
  input  logic [NIB*NSET-1:0] ccr_i,
  input  logic [1:0]          sel_i,
  input  logic [3:0]          cond_i,
  output logic                hit_o,
  output logic                bad_o
);
  logic [NIB-1:0] grp [NSET];

  for (genvar g = 0; g < NSET; g++) begin : g_grp
    assign grp[g] = ccr_i[g*NIB +: NIB];
  end

  logic [NIB-1:0] f;
  logic n, z, v, c, base;

  always_comb begin
    f = grp[sel_i[1]];
    n = f[3];
    z = f[2];
    v = f[1];
    c = f[0];
    case (cond_i[2:0])
      3'd1:    base = z;
      3'd2:    base = z | (n ^ v);
      3'd3:    base = n ^ v;
      3'd4:    base = c | z;
      3'd5:    base = c;
      3'd6:    base = n;
      3'd7:    base = v;
      default: base = 1'b0;
    endcase
    hit_o = base ^ cond_i[3];
    bad_o = sel_i[0];
  end
endmodule

// File: rtl/fcc_eval.sv
module fcc_eval #(
  parameter int NFCC = 4
) (
  input  logic [2*NFCC-1:0] fcc_i,
  input  logic [1:0]        sel_i,
  input  logic [3:0]        cond_i,
  output logic              hit_o
);
  logic [1:0] fld [NFCC];

  for (genvar k = 0; k < NFCC; k++) begin : g_fld
    assign fld[k] = fcc_i[2*k +: 2];
  end

  logic [1:0] cur;
  logic eq, lt, gt, un, base;

  always_comb begin
    cur  = (int'(sel_i) < NFCC) ? fld[sel_i] : fld[0];
    eq   = (cur == 2'd0);
    lt   = (cur == 2'd1);
    gt   = (cur == 2'd2);
    un   = (cur == 2'd3);
    case (cond_i[2:0])
      3'd1:    base = un | lt | gt;
      3'd2:    base = lt | gt;
      3'd3:    base = un | lt;
      3'd4:    base = lt;
      3'd5:    base = un | gt;
      3'd6:    base = gt;
      3'd7:    base = un;
      default: base = 1'b0;
    endcase
    hit_o = base ^ cond_i[3];
  end
endmodule

// File: rtl/rcmp_eval.sv
module rcmp_eval #(
  parameter int REG_W = 64
) (
  input  logic [REG_W-1:0] val_i,
  input  logic [2:0]       code_i,
  output logic             hit_o,
  output logic             bad_o
);
  logic is_zero, is_neg, base;

  always_comb begin
    is_zero = (val_i == '0);
    is_neg  = val_i[REG_W-1];
    case (code_i[1:0])
      2'd1:    base = is_zero;
      2'd2:    base = is_zero | is_neg;
      2'd3:    base = is_neg;
      default: base = 1'b0;
    endcase
    bad_o = (code_i[1:0] == 2'd0);
    hit_o = bad_o ? 1'b0 : (base ^ code_i[2]);
  end
endmodule

// File: rtl/nxt_addr.sv
module nxt_addr
  import dnpc_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int INSN_BYTES = 4
) (
  input  nx_mode_e            mode_i,
  input  logic                hit_i,
  input  logic                annul_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [ADDR_W-1:0]   npc_i,
  input  logic [ADDR_W-1:0]   disp_i,
  output logic [ADDR_W-1:0]   npc_n_o,
  output logic [ADDR_W-1:0]   nnpc_n_o,
  output logic                taken_o
);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);

  logic [ADDR_W-1:0] tgt, seq1, seq2;
  logic              skip;

  always_comb begin
    tgt  = pc_i + disp_i;
    seq1 = npc_i + STEP1;
    seq2 = npc_i + STEP2;
    skip = 1'b0;
    npc_n_o  = npc_i;
    nnpc_n_o = seq1;
    taken_o  = 1'b0;
    case (mode_i)
      NX_ALWAYS: begin
        taken_o = 1'b1;
        if (annul_i) begin
          npc_n_o  = tgt;
          nnpc_n_o = tgt + STEP1;
        end else begin
          nnpc_n_o = tgt;
        end
      end
      NX_NEVER: skip = annul_i;
      NX_COND: begin
        if (hit_i) begin
          taken_o  = 1'b1;
          nnpc_n_o = tgt;
        end else begin
          skip = annul_i;
        end
      end
      default: ;
    endcase
    if (skip) begin
      npc_n_o  = seq1;
      nnpc_n_o = seq2;
    end
  end
endmodule

// File: rtl/dslot_npc_unit.sv
module dslot_npc_unit
  import dnpc_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int REG_W      = 64,
  parameter int NFCC       = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        kind_i,
  input  logic [3:0]        cond_i,
  input  logic [1:0]        sel_i,
  input  logic              annul_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] npc_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic [7:0]        ccr_i,
  input  logic [2*NFCC-1:0] fcc_i,
  input  logic [REG_W-1:0]  reg_val_i,
  output logic [ADDR_W-1:0] npc_o,
  output logic [ADDR_W-1:0] nnpc_o,
  output logic              taken_o,
  output logic              illegal_o
);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);

  logic ihit, ibad, fhit, rhit, rbad;

  icc_eval #(.NIB(4), .NSET(2)) u_icc (
    .ccr_i(ccr_i), .sel_i(sel_i), .cond_i(cond_i),
    .hit_o(ihit), .bad_o(ibad)
  );

  fcc_eval #(.NFCC(NFCC)) u_fcc (
    .fcc_i(fcc_i), .sel_i(sel_i), .cond_i(cond_i), .hit_o(fhit)
  );

  rcmp_eval #(.REG_W(REG_W)) u_rcmp (
    .val_i(reg_val_i), .code_i(cond_i[2:0]), .hit_o(rhit), .bad_o(rbad)
  );

  nx_mode_e mode_c;
  logic     hit_c, illegal_c, flagkind_c;

  always_comb begin
    flagkind_c = (kind_i == KIND_ICC) || (kind_i == KIND_FCC);
    illegal_c  = ((kind_i == KIND_ICC) && ibad) ||
                 ((kind_i == KIND_REG) && rbad);
    case (kind_i)
      KIND_ICC: hit_c = ihit;
      KIND_FCC: hit_c = fhit;
      KIND_REG: hit_c = rhit;
      default:  hit_c = 1'b0;
    endcase
    if (illegal_c || kind_i == KIND_NONE) mode_c = NX_SEQ;
    else if (flagkind_c && cond_i == COND_ALWAYS) mode_c = NX_ALWAYS;
    else if (flagkind_c && cond_i == COND_NEVER) mode_c = NX_NEVER;
    else mode_c = NX_COND;
  end

  logic [ADDR_W-1:0] npc_n, nnpc_n;
  logic              taken_n;

  nxt_addr #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_nxt (
    .mode_i(mode_c), .hit_i(hit_c), .annul_i(annul_i),
    .pc_i(pc_i), .npc_i(npc_i), .disp_i(disp_i),
    .npc_n_o(npc_n), .nnpc_n_o(nnpc_n), .taken_o(taken_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      npc_o     <= '0;
      nnpc_o    <= '0;
      taken_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      npc_o     <= npc_n;
      nnpc_o    <= nnpc_n;
      taken_o   <= taken_n;
      illegal_o <= illegal_c;
    end
  end

  // R1: reset clears every output in the following cycle
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (npc_o == '0 && nnpc_o == '0 && !taken_o && !illegal_o));

  // R2: unconditional branch with annul goes straight to the target
  assert_always_annul_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flagkind_c && !illegal_c && cond_i == COND_ALWAYS && annul_i))
      |-> (taken_o && npc_o == $past(pc_i + disp_i) && nnpc_o == $past(pc_i + disp_i) + STEP1));

  // R4: never-branch is never reported taken
  assert_never_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flagkind_c && cond_i == COND_NEVER)) |-> !taken_o);

  // R6: whenever nothing is taken the two addresses are consecutive
  assert_nt_consecutive_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !taken_o) |-> (nnpc_o == npc_o + STEP1));

  // R11: an illegal encoding never redirects fetch
  assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!taken_o && nnpc_o == npc_o + STEP1));

  // R10: register equal-zero test on a zero operand is taken
  assert_reg_eqz_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind_i == KIND_REG && cond_i[1:0] == 2'd1 && !cond_i[2] && reg_val_i == '0))
      |-> taken_o);
endmodule

// File: tb/sim_dslot_npc_unit.sv
module sim_dslot_npc_unit;
  localparam int AW = 64;
  localparam int RW = 64;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    kind = 2'd3;
  logic [3:0]    cond = '0;
  logic [1:0]    sel = '0;
  logic          annul = 1'b0;
  logic [AW-1:0] pc = '0, npc = '0, disp = '0;
  logic [7:0]    ccr = '0;
  logic [2*NF-1:0] fcc = '0;
  logic [RW-1:0] rv = '0;
  logic [AW-1:0] npc_o, nnpc_o;
  logic          taken_o, illegal_o;

  int n_tests = 0;
  int n_fail  = 0;
  int vec_n   = 0;

  always #4 clk = ~clk;

  dslot_npc_unit #(.ADDR_W(AW), .REG_W(RW), .NFCC(NF), .INSN_BYTES(4)) u0 (
    .clk(clk), .rst(rst), .kind_i(kind), .cond_i(cond), .sel_i(sel),
    .annul_i(annul), .pc_i(pc), .npc_i(npc), .disp_i(disp), .ccr_i(ccr),
    .fcc_i(fcc), .reg_val_i(rv), .npc_o(npc_o), .nnpc_o(nnpc_o),
    .taken_o(taken_o), .illegal_o(illegal_o)
  );

  function automatic bit int_test(input logic [3:0] c, input logic [3:0] f);
    bit r;
    case (c[2:0])
      3'd0: r = 0;
      3'd1: r = f[2];
      3'd2: r = f[2] || (f[3] != f[1]);
      3'd3: r = (f[3] != f[1]);
      3'd4: r = f[0] || f[2];
      3'd5: r = f[0];
      3'd6: r = f[3];
      default: r = f[1];
    endcase
    return c[3] ? !r : r;
  endfunction

  // mask bit index = compare value: 0 equal, 1 less, 2 greater, 3 unordered
  function automatic bit fp_test(input logic [3:0] c, input logic [1:0] v);
    logic [3:0] m;
    case (c)
      4'd0: m = 4'b0000;  4'd1: m = 4'b1110;  4'd2: m = 4'b0110;  4'd3: m = 4'b1010;
      4'd4: m = 4'b0010;  4'd5: m = 4'b1100;  4'd6: m = 4'b0100;  4'd7: m = 4'b1000;
      4'd8: m = 4'b1111;  4'd9: m = 4'b0001;  4'd10: m = 4'b1001; 4'd11: m = 4'b0101;
      4'd12: m = 4'b1101; 4'd13: m = 4'b0011; 4'd14: m = 4'b1011; default: m = 4'b0111;
    endcase
    return m[v];
  endfunction

  function automatic bit reg_test(input logic [2:0] c, input logic signed [RW-1:0] x);
    case (c)
      3'd1: return x == 0;
      3'd2: return x <= 0;
      3'd3: return x < 0;
      3'd5: return x != 0;
      3'd6: return x > 0;
      3'd7: return x >= 0;
      default: return 0;
    endcase
  endfunction

  task automatic run_vec(input logic [1:0] k, input logic [3:0] c, input logic [1:0] s,
                         input logic a, input logic [7:0] cc, input logic [2*NF-1:0] fc,
                         input logic [RW-1:0] r, input string tag);
    logic [AW-1:0] e_npc, e_nnpc, tgt;
    bit e_tk, e_ill, hit, cond_br;
    @(negedge clk);
    vec_n++;
    kind = k; cond = c; sel = s; annul = a; ccr = cc; fcc = fc; rv = r;
    pc   = 64'h0000_0000_0010_0000 + 64'(vec_n) * 64'h40;
    npc  = (vec_n % 3 == 0) ? pc + 64'h100 : pc + 64'd4;
    disp = vec_n[0] ? -64'h240 : 64'h3c4;
    tgt  = pc + disp;
    e_ill = (k == 2'd2 && c[1:0] == 2'd0) || (k == 2'd0 && s[0]);
    e_npc = npc; e_nnpc = npc + 4; e_tk = 0;
    cond_br = 0; hit = 0;
    if (!e_ill && k != 2'd3) begin
      if (k != 2'd2 && c == 4'd8) begin
        e_tk = 1;
        if (a) begin e_npc = tgt; e_nnpc = tgt + 4; end
        else e_nnpc = tgt;
      end else if (k != 2'd2 && c == 4'd0) begin
        if (a) begin e_npc = npc + 4; e_nnpc = npc + 8; end
      end else begin
        cond_br = 1;
        if (k == 2'd0) hit = int_test(c, s[1] ? cc[7:4] : cc[3:0]);
        else if (k == 2'd1) hit = fp_test(c, fc[2*s +: 2]);
        else hit = reg_test(c[2:0], r);
        if (hit) begin e_tk = 1; e_nnpc = tgt; end
        else if (a) begin e_npc = npc + 4; e_nnpc = npc + 8; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (npc_o !== e_npc || nnpc_o !== e_nnpc || taken_o !== e_tk || illegal_o !== e_ill) begin
      n_fail++;
      $display("FAIL %s k=%0d c=%0d s=%0d a=%0d: got npc=%h nnpc=%h tk=%0b ill=%0b exp npc=%h nnpc=%h tk=%0b ill=%0b",
               tag, k, c, s, a, npc_o, nnpc_o, taken_o, illegal_o, e_npc, e_nnpc, e_tk, e_ill);
    end
  endtask

  initial begin : watchdog
    #1500000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [RW-1:0] rvals [6];
    rvals[0] = 64'h8000_0000_0000_0000; rvals[1] = '1; rvals[2] = '0;
    rvals[3] = 64'd1; rvals[4] = 64'h7fff_ffff_ffff_ffff; rvals[5] = 64'h0000_0001_0000_0000;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (npc_o !== '0 || nnpc_o !== '0 || taken_o !== 1'b0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got npc=%h nnpc=%h tk=%0b ill=%0b exp all zero",
               npc_o, nnpc_o, taken_o, illegal_o);
    end
    rst = 1'b0;

    // Directed: R2 R3 R4 R5 R6 R7 R11
    run_vec(2'd0, 4'd8, 2'd0, 1'b1, 8'h00, '0, '0, "R2");
    run_vec(2'd1, 4'd8, 2'd3, 1'b1, 8'h00, '0, '0, "R2");
    run_vec(2'd0, 4'd8, 2'd2, 1'b0, 8'h00, '0, '0, "R3");
    run_vec(2'd1, 4'd0, 2'd1, 1'b0, 8'h00, '0, '0, "R4");
    run_vec(2'd0, 4'd0, 2'd0, 1'b1, 8'hff, '0, '0, "R4");
    run_vec(2'd0, 4'd1, 2'd0, 1'b1, 8'h04, '0, '0, "R5");
    run_vec(2'd0, 4'd1, 2'd0, 1'b1, 8'h00, '0, '0, "R6");
    run_vec(2'd0, 4'd1, 2'd0, 1'b0, 8'h00, '0, '0, "R6");
    run_vec(2'd3, 4'd8, 2'd0, 1'b1, 8'hff, '1, '0, "R7");
    run_vec(2'd2, 4'd4, 2'd0, 1'b1, 8'h00, '0, '0, "R11");
    run_vec(2'd0, 4'd8, 2'd1, 1'b1, 8'h00, '0, '0, "R11");

    // R8 sweep: integer flags, every cond, group pattern, selector, annul
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        for (int s = 0; s < 4; s++)
          for (int a = 0; a < 2; a++)
            run_vec(2'd0, 4'(c), 2'(s), a[0], (s[1] ? {4'(f), 4'(~f)} : {4'(~f), 4'(f)}),
                    '0, '0, s[0] ? "R11" : "R8");

    // R9 sweep: floating-point fields, every field selected, every value
    for (int c = 0; c < 16; c++)
      for (int v = 0; v < 4; v++)
        for (int s = 0; s < 4; s++)
          for (int a = 0; a < 2; a++) begin
            logic [2*NF-1:0] fv;
            fv = 8'b1110_0100 ^ 8'h00;
            fv[2*s +: 2] = 2'(v);
            fv[2*((s + 1) % 4) +: 2] = 2'(~v);
            run_vec(2'd1, 4'(c), 2'(s), a[0], 8'h00, fv, '0, "R9");
          end

    // R10 sweep: register compare, bit 3 of cond toggled to show it is ignored
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 6; i++)
        for (int a = 0; a < 2; a++)
          run_vec(2'd2, 4'(c), 2'(i % 4), a[0], 8'h00, '0, rvals[i],
                  (c % 4 == 0) ? "R11" : "R10");

    // R7: no-branch kind with every cond
    for (int c = 0; c < 16; c++)
      run_vec(2'd3, 4'(c), 2'd0, c[0], 8'h5a, 8'h1b, '0, "R7");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule